// File: doc/BRIEF.md
# Fetch Address Select and Next-Address Guess

This block sits in the fetch stage of a five-stage in-order pipeline. Every cycle it decides which address the instruction memory should be read from, and it produces a guess of the following fetch address for the instruction that was just read. The guess is held in an internal next-address register that reloads on each rising clock edge unless the pipeline holds fetch.

The guess is static. Calls and every jump, whether conditional or not, are guessed to go to the destination constant carried by the instruction. All other instructions, including a return, are guessed to continue at the sequential successor address. No return target is ever guessed.

Two late corrections override the guess. A jump that reaches the memory stage with a false condition redirects fetch to the fall-through address carried along with it. A return that reaches write-back redirects fetch to the address it loaded from the stack. The return correction wins over the jump correction, and both win over the register.

Top module: `pcsel_fetch`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release with no correction pending, the fetch address is 0.
- R2: When the fetched instruction code is neither 4'h7 (jump), 4'h8 (call) nor 4'h9 (return), the guessed next address equals the sequential successor input.
- R3: When the fetched instruction code is 4'h8 (call), the guessed next address equals the constant field input.
- R4: When the fetched instruction code is 4'h7 (jump, of any condition), the guessed next address equals the constant field input.
- R5: When the fetched instruction code is 4'h9 (return), the guessed next address is the sequential successor input, not the constant field.
- R6: When the memory-stage code is 4'h7 with its condition flag low, and write-back does not hold code 4'h9, the fetch address equals the memory-stage fall-through address.
- R7: When the write-back code is 4'h9, the fetch address equals the write-back loaded value, regardless of the memory stage.
- R8: With no correction active, the fetch address equals the value of the next-address register.
- R9: The next-address register takes the guessed next address on every rising edge where the hold input is low, and keeps its value on edges where it is high.
- R10: A memory-stage jump with its condition flag high, or a memory-stage code other than 4'h7, causes no correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_stall_i | input | 1 | Hold the next-address register |
| f_icode_i | input | 4 | Code of the instruction just fetched |
| f_seq_pc_i | input | AW | Sequential successor address of the fetched instruction |
| f_const_i | input | AW | Constant (destination) field of the fetched instruction |
| m_icode_i | input | 4 | Instruction code in the memory stage |
| m_cond_i | input | 1 | Condition outcome in the memory stage |
| m_fall_pc_i | input | AW | Fall-through address carried in the memory stage |
| w_icode_i | input | 4 | Instruction code in the write-back stage |
| w_load_val_i | input | AW | Value loaded from memory, held in write-back |
| fetch_pc_o | output | AW | Address to fetch this cycle |
| pred_pc_o | output | AW | Guessed next address for the fetched instruction |

## Verification
The bench aims at the cycle where a return in write-back and a not-taken jump in the memory stage arrive together; a design with the priority reversed would fetch the fall-through address instead of the loaded return target. It drives a taken jump in the memory stage, where a design that ignored the condition flag would redirect fetch needlessly, and a return in fetch, where a design that treated returns like calls would jump to a meaningless constant. Hold cycles are mixed in so that a register that reloaded under hold, or one that failed to reload afterwards, shows up as a wrong fetch address one cycle later.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

  localparam int IC_W = 4;

  localparam logic [IC_W-1:0] IC_JUMP = 4'h7;
  localparam logic [IC_W-1:0] IC_CALL = 4'h8;
  localparam logic [IC_W-1:0] IC_RET  = 4'h9;

  typedef enum logic {
    GUESS_SEQ,
    GUESS_DEST
  } guess_src_e;

  typedef enum logic [1:0] {
    FSRC_REG,
    FSRC_FALL,
    FSRC_RET
  } fetch_src_e;

  // Static guess: calls and all jumps go to the destination constant.
  function automatic guess_src_e guess_source(input logic [IC_W-1:0] icode);
    guess_src_e src;
    case (icode)
      IC_CALL, IC_JUMP: src = GUESS_DEST;
      default:          src = GUESS_SEQ;
    endcase
    return src;
  endfunction

  // Correction priority: return in write-back, then failed jump in memory.
  function automatic fetch_src_e fetch_source(input logic [IC_W-1:0] w_icode,
                                              input logic [IC_W-1:0] m_icode,
                                              input logic            m_cond);
    fetch_src_e src;
    if (w_icode == IC_RET)
      src = FSRC_RET;
    else if ((m_icode == IC_JUMP) && !m_cond)
      src = FSRC_FALL;
    else
      src = FSRC_REG;
    return src;
  endfunction

endpackage

// File: rtl/pcsel_guess.sv
module pcsel_guess
  import pcsel_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [IC_W-1:0] icode_i,
  input  logic [AW-1:0]   seq_pc_i,
  input  logic [AW-1:0]   const_i,
  output logic [AW-1:0]   guess_o
);

  guess_src_e src;

  assign src = guess_source(icode_i);

  always_comb begin
    case (src)
      GUESS_DEST: guess_o = const_i;
      default:    guess_o = seq_pc_i;
    endcase
  end

endmodule

// File: rtl/pcsel_next_reg.sv
module pcsel_next_reg #(
  parameter int              AW       = 32,
  parameter logic [AW-1:0]   RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_o <= RESET_PC;
    else if (!hold_i)
      q_o <= d_i;
  end

endmodule

// File: rtl/pcsel_correct.sv
module pcsel_correct
  import pcsel_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [IC_W-1:0] m_icode_i,
  input  logic            m_cond_i,
  input  logic [AW-1:0]   m_fall_pc_i,
  input  logic [IC_W-1:0] w_icode_i,
  input  logic [AW-1:0]   w_load_val_i,
  input  logic [AW-1:0]   reg_pc_i,
  output logic [AW-1:0]   fetch_pc_o
);

  fetch_src_e src;

  assign src = fetch_source(w_icode_i, m_icode_i, m_cond_i);

  always_comb begin
    case (src)
      FSRC_RET:  fetch_pc_o = w_load_val_i;
      FSRC_FALL: fetch_pc_o = m_fall_pc_i;
      default:   fetch_pc_o = reg_pc_i;
    endcase
  end

endmodule

// File: rtl/pcsel_fetch.sv
module pcsel_fetch
  import pcsel_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_stall_i,
  input  logic [IC_W-1:0] f_icode_i,
  input  logic [AW-1:0]   f_seq_pc_i,
  input  logic [AW-1:0]   f_const_i,
  input  logic [IC_W-1:0] m_icode_i,
  input  logic            m_cond_i,
  input  logic [AW-1:0]   m_fall_pc_i,
  input  logic [IC_W-1:0] w_icode_i,
  input  logic [AW-1:0]   w_load_val_i,
  output logic [AW-1:0]   fetch_pc_o,
  output logic [AW-1:0]   pred_pc_o
);

  localparam logic [AW-1:0] BOOT_PC = '0;

  logic [AW-1:0] pred_q;

  pcsel_guess #(.AW(AW)) guess_i (
    .icode_i  (f_icode_i),
    .seq_pc_i (f_seq_pc_i),
    .const_i  (f_const_i),
    .guess_o  (pred_pc_o)
  );

  pcsel_next_reg #(.AW(AW), .RESET_PC(BOOT_PC)) next_reg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (pc_stall_i),
    .d_i    (pred_pc_o),
    .q_o    (pred_q)
  );

  pcsel_correct #(.AW(AW)) correct_i (
    .m_icode_i    (m_icode_i),
    .m_cond_i     (m_cond_i),
    .m_fall_pc_i  (m_fall_pc_i),
    .w_icode_i    (w_icode_i),
    .w_load_val_i (w_load_val_i),
    .reg_pc_i     (pred_q),
    .fetch_pc_o   (fetch_pc_o)
  );

endmodule

// File: rtl/pcsel_fetch_chk.sv
module pcsel_fetch_chk
  import pcsel_pkg::*;
#(
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pc_stall_i,
  input logic [IC_W-1:0] f_icode_i,
  input logic [AW-1:0]   f_seq_pc_i,
  input logic [AW-1:0]   f_const_i,
  input logic [IC_W-1:0] m_icode_i,
  input logic            m_cond_i,
  input logic [AW-1:0]   m_fall_pc_i,
  input logic [IC_W-1:0] w_icode_i,
  input logic [AW-1:0]   w_load_val_i,
  input logic [AW-1:0]   fetch_pc_o,
  input logic [AW-1:0]   pred_pc_o,
  input logic [AW-1:0]   pred_q
);

  // R7
  ret_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icode_i == IC_RET) |-> (fetch_pc_o == w_load_val_i));

  // R6
  fall_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_icode_i != IC_RET) && (m_icode_i == IC_JUMP) && !m_cond_i)
      |-> (fetch_pc_o == m_fall_pc_i));

  // R10
  taken_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_icode_i != IC_RET) && ((m_icode_i != IC_JUMP) || m_cond_i))
      |-> (fetch_pc_o == pred_q));

  // R9
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_stall_i |=> (pred_q == $past(pred_pc_o)));

  // R9
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall_i |=> $stable(pred_q));

  // R3
  call_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_icode_i == IC_CALL) |-> (pred_pc_o == f_const_i));

  // R4
  jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_icode_i == IC_JUMP) |-> (pred_pc_o == f_const_i));

  // R5
  ret_no_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_icode_i == IC_RET) |-> (pred_pc_o == f_seq_pc_i));

endmodule

bind pcsel_fetch pcsel_fetch_chk #(.AW(AW)) chk_i (.*);

// File: tb/pcsel_fetch_tb.sv
`timescale 1ns/100ps
module pcsel_fetch_tb_top;

  localparam int AW = 32;

  typedef struct {
    logic [AW-1:0] exp_fetch;
    logic [AW-1:0] exp_pred;
    string         tag_f;
    string         tag_p;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pc_stall_i = 1'b0;
  logic [3:0]    f_icode_i = 4'h1;
  logic [AW-1:0] f_seq_pc_i = '0;
  logic [AW-1:0] f_const_i = '0;
  logic [3:0]    m_icode_i = 4'h1;
  logic          m_cond_i = 1'b1;
  logic [AW-1:0] m_fall_pc_i = '0;
  logic [3:0]    w_icode_i = 4'h1;
  logic [AW-1:0] w_load_val_i = '0;
  logic [AW-1:0] fetch_pc_o;
  logic [AW-1:0] pred_pc_o;

  item_t         sb_q[$];
  int            checks = 0;
  int            errors = 0;
  logic [AW-1:0] model_reg = '0;
  logic [AW-1:0] last_pred = '0;
  logic          last_hold = 1'b1;
  bit            done = 0;

  always #2.5 clk = ~clk;

  pcsel_fetch #(.AW(AW)) dut_i (.*);

  task automatic check(input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected results.
  task automatic drive(input logic [3:0] fic, input logic [AW-1:0] fseq,
                       input logic [AW-1:0] fcon, input logic hold,
                       input logic [3:0] mic, input logic mcond,
                       input logic [AW-1:0] mfall, input logic [3:0] wic,
                       input logic [AW-1:0] wval);
    item_t it;
    @(negedge clk);
    if (!last_hold) model_reg = last_pred;
    f_icode_i = fic; f_seq_pc_i = fseq; f_const_i = fcon; pc_stall_i = hold;
    m_icode_i = mic; m_cond_i = mcond; m_fall_pc_i = mfall;
    w_icode_i = wic; w_load_val_i = wval;
    if (wic == 4'h9) begin
      it.exp_fetch = wval; it.tag_f = "R7";
    end else if (mic == 4'h7 && !mcond) begin
      it.exp_fetch = mfall; it.tag_f = "R6";
    end else begin
      it.exp_fetch = model_reg;
      it.tag_f = (mic == 4'h7) ? "R10" : "R8/R9";
    end
    if (fic == 4'h8) begin
      it.exp_pred = fcon; it.tag_p = "R3";
    end else if (fic == 4'h7) begin
      it.exp_pred = fcon; it.tag_p = "R4";
    end else if (fic == 4'h9) begin
      it.exp_pred = fseq; it.tag_p = "R5";
    end else begin
      it.exp_pred = fseq; it.tag_p = "R2";
    end
    sb_q.push_back(it);
    last_pred = it.exp_pred;
    last_hold = hold;
  endtask

  // Monitor: compares outputs just after each stimulus settles.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag_f, fetch_pc_o, it.exp_fetch);
        check(it.tag_p, pred_pc_o, it.exp_pred);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 in reset", fetch_pc_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first fetch is 0; R2 sequential guess
    drive(4'h1, 32'h2, 32'h0, 0, 4'h1, 1, 32'h0, 4'h1, 32'h0);
    drive(4'h6, 32'h10, 32'h999, 0, 4'h1, 1, 32'h0, 4'h1, 32'h0);
    // R3 call
    drive(4'h8, 32'h20, 32'h400, 0, 4'h1, 1, 32'h0, 4'h1, 32'h0);
    // R4 jump
    drive(4'h7, 32'h405, 32'h800, 0, 4'h1, 1, 32'h0, 4'h1, 32'h0);
    // R9 hold
    drive(4'h3, 32'h806, 32'h1, 1, 4'h1, 1, 32'h0, 4'h1, 32'h0);
    drive(4'h3, 32'h806, 32'h1, 0, 4'h1, 1, 32'h0, 4'h1, 32'h0);
    // R6 fall-through, R5 return fetched
    drive(4'h9, 32'h807, 32'hdead, 0, 4'h7, 0, 32'h409, 4'h1, 32'h0);
    // R10 taken jump in memory
    drive(4'h1, 32'h808, 32'h0, 0, 4'h7, 1, 32'h555, 4'h1, 32'h0);
    // R7 priority over R6
    drive(4'h1, 32'h900, 32'h0, 0, 4'h7, 0, 32'h777, 4'h9, 32'h1234);
    drive(4'h1, 32'h904, 32'h0, 0, 4'h1, 1, 32'h0, 4'h9, 32'h2000);
    // R10 non-jump code with low flag
    drive(4'h5, 32'ha00, 32'h0, 0, 4'h5, 0, 32'h666, 4'h1, 32'h0);
    for (int i = 0; i < 60; i++) begin
      drive(4'(i % 12), 32'h1000 + 32'(i * 6), 32'h8000 + 32'(i * 40),
            (i % 5) == 3, ((i % 3) == 0) ? 4'h7 : 4'(i % 7),
            (i % 4) == 1, 32'h3000 + 32'(i), ((i % 7) == 2) ? 4'h9 : 4'h2,
            32'h5000 + 32'(i * 3));
    end
    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule